// File: doc/BRIEF.md
# Click-Coded Single-Wire Byte Transmitter

This block sends one byte at a time over a shared open-drain line that a pull-up holds high while idle. Each byte travels as a frame of timed slots. A slot either carries a click, which is a short low pulse followed by a longer high gap, or it is empty and stays high for the whole slot. A frame opens with two click slots. Then each data bit takes two slots, starting with the least significant bit: a one puts its click in the first slot and a zero puts it in the second. Two click slots close the frame. Each bit therefore carries exactly one click, so a receiver can decode the bit from where that click falls in time.

The host offers a byte together with a start pulse. The block takes the byte only while it is not busy. If the host also raises the sense request with that start, the block first waits until the line has been seen high for an unbroken window of samples. Any low sample starts the window again from zero. The host raises the sense request for the first byte of a packet. It leaves the request low for the following bytes, which then go out with no deferral. The block drives the line only while a frame is on the wire. After each frame it adds a configurable idle gap before it accepts the next byte. All durations are counted in ticks, and a tick is a parameterised division of the clock.

Top module: `click_tx`

## Requirements
- R1: During reset and after it, `busy_o` and `line_oe_o` are 0 and `line_o` is 1.
- R2: When `start_i` is 1 while idle and `sense_req_i` is 0, the block captures `data_i`. The frame starts on the next cycle with `busy_o` and `line_oe_o` at 1. This holds even when `line_i` is low.
- R3: A click slot drives `line_o` low for CLICK_LEN ticks and then high for GAP_LEN ticks. An empty slot holds `line_o` high for CLICK_LEN+GAP_LEN ticks.
- R4: A frame is 20 slots: slots 0 and 1 are clicks, slots 2..17 carry data bits 0..7 in pairs (bit k in slots 2+2k and 3+2k), and slots 18 and 19 are clicks.
- R5: A data bit of 1 puts its click in the first slot of its pair and leaves the second slot empty. A data bit of 0 leaves the first slot empty and puts its click in the second slot.
- R6: `line_oe_o` is 1 for exactly the 20·(CLICK_LEN+GAP_LEN) ticks of the frame. Whenever `line_oe_o` is 0, `line_o` is 1.
- R7: Once the frame ends, `busy_o` stays high for BYTE_GAP more ticks with the line released, and then goes low.
- R8: A start request while `busy_o` is 1 is ignored, and so is any change of `data_i`. The frame in flight is unchanged, and no further frame follows it.
- R9: When `start_i` and `sense_req_i` are both 1 while idle, the frame begins only after SENSE_OUTER·SENSE_INNER consecutive high samples of `line_i` (default 2550 ticks with the line quiet).
- R10: During the sense wait, a single low sample of `line_i` clears the quiet window. The frame then needs a complete new window of high samples counted from the sample after the low one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to send `data_i` |
| sense_req_i | input | 1 | Run the quiet-line check before this byte |
| data_i | input | DATA_W | Byte to send |
| line_i | input | 1 | Sampled level of the shared line |
| busy_o | output | 1 | Byte accepted and not yet finished |
| line_o | output | 1 | Level to drive on the line |
| line_oe_o | output | 1 | Line driver enable |

## Verification
A slot counter that has slipped shows up at the line within one slot (20 ticks). A click then lands in the wrong slot, or a low pulse runs longer than CLICK_LEN, which the checker flags on the cycle it happens. A wrong captured byte or a wrong bit-pair decode changes the frame waveform within 40 ticks of the affected bit. A wrong quiet-window count or a wrong restart moves the first edge of `line_oe_o` by a measurable number of cycles. A state machine that does not return to idle shows as `busy_o` staying high past the expected gap, or as a second frame appearing.

// File: rtl/click_pkg.sv
package click_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SENSE = 2'd1,
    ST_FRAME = 2'd2,
    ST_GAP   = 2'd3
  } tx_state_e;

  localparam int unsigned LEAD_CLICKS = 2;
  localparam int unsigned TAIL_CLICKS = 2;
  localparam int unsigned SLOTS_PER_BIT = 2;
endpackage

// File: rtl/click_tick.sv
module click_tick #(
  parameter int unsigned DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/click_quiet.sv
module click_quiet #(
  parameter int unsigned QUIET_LEN = 2550
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic line_i,
  output logic done_o
);
  localparam int unsigned QW = $clog2(QUIET_LEN + 1);

  logic [QW-1:0] cnt_q;

  assign done_o = en_i && tick_i && line_i && (cnt_q == QW'(QUIET_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!en_i)    cnt_q <= '0;
    else if (tick_i) begin
      if (!line_i)     cnt_q <= '0;  // any low sample restarts the window
      else if (!done_o) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/click_slot_seq.sv
module click_slot_seq #(
  parameter int unsigned CLICK_LEN = 5,
  parameter int unsigned SLOT_LEN  = 20,
  parameter int unsigned SLOTS     = 20,
  localparam int unsigned PH_W     = $clog2(SLOT_LEN),
  localparam int unsigned SL_W     = $clog2(SLOTS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            tick_i,
  output logic [SL_W-1:0] slot_o,
  output logic            pulse_o,
  output logic            last_o
);
  logic [PH_W-1:0] phase_q;
  logic [SL_W-1:0] slot_q;
  logic            end_ph;

  assign end_ph  = (phase_q == PH_W'(SLOT_LEN - 1));
  assign last_o  = run_i && tick_i && end_ph && (slot_q == SL_W'(SLOTS - 1));
  assign pulse_o = (phase_q < PH_W'(CLICK_LEN));
  assign slot_o  = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      slot_q  <= '0;
    end else if (!run_i) begin
      phase_q <= '0;
      slot_q  <= '0;
    end else if (tick_i) begin
      if (end_ph) begin
        phase_q <= '0;
        slot_q  <= last_o ? '0 : slot_q + 1'b1;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/click_tx.sv
module click_tx
  import click_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CLICK_LEN   = 5,
  parameter int unsigned GAP_LEN     = 15,
  parameter int unsigned SENSE_OUTER = 255,
  parameter int unsigned SENSE_INNER = 10,
  parameter int unsigned BYTE_GAP    = 8,
  parameter int unsigned TICK_DIV    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sense_req_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              line_i,
  output logic              busy_o,
  output logic              line_o,
  output logic              line_oe_o
);
  localparam int unsigned SLOT_LEN   = CLICK_LEN + GAP_LEN;
  localparam int unsigned DATA_SLOTS = SLOTS_PER_BIT * DATA_W;
  localparam int unsigned SLOTS      = LEAD_CLICKS + DATA_SLOTS + TAIL_CLICKS;
  localparam int unsigned SL_W       = $clog2(SLOTS);
  localparam int unsigned QUIET_LEN  = SENSE_OUTER * SENSE_INNER;

  tx_state_e         state_q;
  logic [DATA_W-1:0] data_q;
  logic              tick;
  logic              quiet_done;
  logic              frame_last;
  logic              gap_done;
  logic [SL_W-1:0]   slot;
  logic              pulse;
  logic              click_slot;
  logic              in_frame;

  assign in_frame = (state_q == ST_FRAME);

  click_tick #(.DIV(TICK_DIV)) tick_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  click_quiet #(.QUIET_LEN(QUIET_LEN)) quiet_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_SENSE),
    .tick_i (tick),
    .line_i (line_i),
    .done_o (quiet_done)
  );

  click_slot_seq #(
    .CLICK_LEN (CLICK_LEN),
    .SLOT_LEN  (SLOT_LEN),
    .SLOTS     (SLOTS)
  ) seq_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (in_frame),
    .tick_i  (tick),
    .slot_o  (slot),
    .pulse_o (pulse),
    .last_o  (frame_last)
  );

  // slot decode: lead/tail clicks, else bit pair (click first for 1, second for 0)
  logic [SL_W-1:0] rel;
  logic [SL_W-1:0] rel_half;
  logic            bit_val;

  always_comb begin
    rel      = slot - SL_W'(LEAD_CLICKS);
    rel_half = rel >> 1;
    bit_val  = 1'b0;
    for (int i = 0; i < int'(DATA_W); i++) begin
      if (rel_half == SL_W'(i)) bit_val = data_q[i];
    end
    if (slot < SL_W'(LEAD_CLICKS))                    click_slot = 1'b1;
    else if (slot >= SL_W'(LEAD_CLICKS + DATA_SLOTS)) click_slot = 1'b1;
    else                                              click_slot = (~rel[0] == bit_val);
  end

  assign line_oe_o = in_frame;
  assign line_o    = !(in_frame && click_slot && pulse);
  assign busy_o    = (state_q != ST_IDLE);

  generate
    if (BYTE_GAP > 0) begin : g_gap
      localparam int unsigned GW = (BYTE_GAP > 1) ? $clog2(BYTE_GAP) : 1;
      logic [GW-1:0] gap_q;
      assign gap_done = (state_q == ST_GAP) && tick && (gap_q == GW'(BYTE_GAP - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 gap_q <= '0;
        else if (state_q != ST_GAP)  gap_q <= '0;
        else if (tick && !gap_done)  gap_q <= gap_q + 1'b1;
      end
    end else begin : g_nogap
      assign gap_done = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          data_q  <= data_i;
          state_q <= sense_req_i ? ST_SENSE : ST_FRAME;
        end
        ST_SENSE: if (quiet_done) state_q <= ST_FRAME;
        ST_FRAME: if (frame_last) state_q <= (BYTE_GAP > 0) ? ST_GAP : ST_IDLE;
        ST_GAP:   if (gap_done)   state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/click_tx_chk.sv
module click_tx_chk #(
  parameter int unsigned CLICK_LEN = 5,
  parameter int unsigned TICK_DIV  = 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic line_o,
  input logic line_oe_o
);
  localparam int unsigned MAX_LOW = CLICK_LEN * TICK_DIV;

  logic [15:0] low_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  low_run_q <= '0;
    else if (line_o)              low_run_q <= '0;
    else if (low_run_q != 16'hFFFF) low_run_q <= low_run_q + 1'b1;
  end

  assert_released_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_oe_o |-> line_o);

  assert_drive_while_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_oe_o |-> busy_o);

  assert_busy_from_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_frame_opens_click_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_oe_o) |-> !line_o);

  assert_click_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_run_q <= 16'(MAX_LOW));

  assert_release_after_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !line_oe_o);
endmodule

bind click_tx click_tx_chk #(.CLICK_LEN(CLICK_LEN), .TICK_DIV(TICK_DIV)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .line_o    (line_o),
  .line_oe_o (line_oe_o)
);

// File: tb/click_tx_tb_top.sv
`timescale 1ns/1ps
module click_tx_tb_top;
  localparam int CLICK = 5;
  localparam int SLOT  = 20;
  localparam int FRAME = 400;
  localparam int GAP   = 8;
  localparam int QUIET = 2550;
  localparam int NV    = 7;

  // stimulus: data, sense request, low-pulse position (-1 none), expected wait
  localparam logic [7:0] V_DATA  [NV] = '{8'hA5, 8'h00, 8'hFF, 8'h01, 8'h80, 8'hDB, 8'hC0};
  localparam bit         V_SENSE [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam int         V_PULSE [NV] = '{-1, -1, -1, -1, 100, -1, 2000};
  localparam int         V_WAIT  [NV] = '{0, 0, 0, QUIET, 100 + 1 + QUIET, 0, 2000 + 1 + QUIET};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       sense = 1'b0;
  logic [7:0] data = 8'h00;
  logic       line_in = 1'b1;
  logic       busy, line_out, oe;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  click_tx dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .sense_req_i (sense),
    .data_i      (data),
    .line_i      (line_in),
    .busy_o      (busy),
    .line_o      (line_out),
    .line_oe_o   (oe)
  );

  function automatic logic exp_line(input logic [7:0] d, input int c);
    int  s   = c / SLOT;
    int  ph  = c % SLOT;
    bit  clk_slot;
    if (s < 2 || s >= 18) clk_slot = 1'b1;
    else clk_slot = (((s - 2) % 2) == 0) == d[(s - 2) / 2];
    return !(clk_slot && ph < CLICK);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_byte(input logic [7:0] d, input bit sn, input int pulse_at,
                          input int exp_wait, input bit intrude);
    int wait_n = 0;
    int mism = 0;
    int oe_bad = 0;
    int gap_n = 0;
    int gap_bad = 0;
    @(negedge clk);
    data = d; sense = sn; start = 1'b1;
    fork
      begin
        if (pulse_at >= 0) begin
          repeat (pulse_at + 1) @(negedge clk);
          line_in = 1'b0;
          @(negedge clk);
          line_in = 1'b1;
        end
      end
      begin
        if (intrude) begin
          repeat (exp_wait + 60) @(negedge clk);
          start = 1'b1; data = ~d;
          @(negedge clk);
          start = 1'b0;
        end
      end
      begin
        @(negedge clk);
        start = 1'b0; sense = 1'b0;
        while (!oe && wait_n < 6000) begin
          wait_n++;
          @(negedge clk);
        end
        for (int c = 0; c < FRAME; c++) begin
          if (!oe) oe_bad++;
          if (line_out !== exp_line(d, c)) mism++;
          @(negedge clk);
        end
        while (busy && gap_n < 1000) begin
          if (oe || !line_out) gap_bad++;
          gap_n++;
          @(negedge clk);
        end
      end
    join
    check(wait_n == exp_wait, sn ? "R9/R10 sense wait" : "R2 start wait", wait_n, exp_wait);
    check(mism == 0, "R3/R4/R5 frame waveform mismatches", mism, 0);
    check(oe_bad == 0, "R6 enable held through frame", oe_bad, 0);
    check(gap_n == GAP && gap_bad == 0, "R7 gap length / released during gap",
          gap_n * 100 + gap_bad, GAP * 100);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && oe == 1'b0 && line_out == 1'b1, "R1 outputs in reset",
          {busy, oe, line_out}, 3'b001);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && oe == 1'b0 && line_out == 1'b1, "R1 outputs after reset",
          {busy, oe, line_out}, 3'b001);

    for (int v = 0; v < NV; v++) begin
      run_byte(V_DATA[v], V_SENSE[v], V_PULSE[v], V_WAIT[v], 1'b0);
    end

    // R2: no sense request, line held low: no deferral
    line_in = 1'b0;
    run_byte(8'h5A, 1'b0, -1, 0, 1'b0);
    line_in = 1'b1;

    // R8: start with new data mid-frame is ignored
    run_byte(8'h3C, 1'b0, -1, 0, 1'b1);
    begin
      int stray = 0;
      for (int i = 0; i < 50; i++) begin
        if (busy || oe || !line_out) stray++;
        @(negedge clk);
      end
      check(stray == 0, "R8 no frame after ignored start", stray, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule